// File: doc/BRIEF.md
# Prescaled Timer with Deferred Compare Reset

The block is a 16-bit up-counter advanced by an external count-source tick through a selectable divider of 1, 2, 4 or 8. A 16-bit compare register sits beside it. When the compare mode field holds the trigger code and the counter equals the compare value, the counter is cleared. The clear is not immediate: it waits for the next divider rollover, so the counter stays at the compare value for a full divided interval. The counter therefore repeats every (x+1)·P source ticks for compare value x and divide ratio P. When the clear takes effect, the block raises a one-cycle trigger pulse and sets a sticky compare flag. A separate sticky flag records a natural wrap from 16'hFFFF to zero.

Software reaches the block through a byte-wide register port. Writing the high byte of the counter only fills a holding buffer. The counter takes the buffered high byte and the written low byte together on the low-byte write, and that same write restarts the divider phase. Reading the low byte captures the live high byte, so a following high-byte read returns the value that belongs with that low byte. Clearing the count enable freezes both the divider and the counter, and register writes are still accepted in that state.

Top module: `cmp_timer`

## Requirements
- R1: After reset, reads of the six registers (0 counter low, 1 counter high, 2 compare low, 3 compare high, 4 control, 5 flags) return 0, and the trigger and both flag outputs are low.
- R2: The counter advances once per P accepted ticks, where control bits [1:0] select P: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8. A tick is accepted when count enable and the source tick are both high at a clock edge.
- R3: When control bits [5:2] hold 4'b1011 and the counter equals the compare value x, the counter is cleared at the next divider rollover instead of being incremented, so it holds x for P ticks and the repeat period is (x+1)·P ticks. With any other mode code the counter passes the compare value and no clear or trigger happens.
- R4: The trigger output is high for one clock cycle after each compare clear, and the counter reads 0 during that cycle.
- R5: The compare flag (flags bit 1) is set together with the trigger and stays set until a write to register 5 with bit 1 high. A write with bit 1 low leaves it set.
- R6: The overflow flag (flags bit 0) is set when the counter wraps from 16'hFFFF to 0 and is cleared by a write to register 5 with bit 0 high. A compare clear from 16'hFFFF does not set it.
- R7: A write to register 1 only loads a buffer. The counter changes only on the next write to register 0, which loads both bytes at once.
- R8: A write to register 1 does not change the divider phase, so the trigger period stays (x+1)·P across it.
- R9: A read of register 0 captures the counter's high byte. Later reads of register 1 return the captured byte until the next read of register 0.
- R10: A write to register 0 restarts the divider, so the first increment after it needs a full P accepted ticks.
- R11: While count enable is low, the counter and divider hold their values even if the source tick is high. Register writes are still taken in that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count enable; low freezes divider and counter |
| src_tick | input | 1 | Count-source tick, sampled each clock |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; on register 0 it captures the high byte |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| trig | output | 1 | One-cycle pulse on a compare clear |
| cmp_flag | output | 1 | Sticky compare flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The trigger period is swept over all four divide ratios and several compare values, including zero, where the counter never leaves 0. The measured cycle count separates a deferred clear, (x+1)·P, from an immediate one, x·P+1. A second run with the source ticking on alternate cycles separates ticks from clocks. Point tests stop the counter one tick before and one tick after the rollover to show that it holds at the compare value, and they repeat the period measurement with a high-byte write in the middle to show that the cadence is unchanged. The remaining tests cover wrap against compare clear at 16'hFFFF, the stale high byte returned after a captured low read, and the divider restart on a low write.

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter logic [3:0] TRIG_MODE = 4'b1011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_en,
  input  logic       src_tick,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       trig,
  output logic       cmp_flag,
  output logic       ovf_flag
);
  localparam logic [2:0] A_TLO = 3'd0;
  localparam logic [2:0] A_THI = 3'd1;
  localparam logic [2:0] A_CLO = 3'd2;
  localparam logic [2:0] A_CHI = 3'd3;
  localparam logic [2:0] A_CTL = 3'd4;
  localparam logic [2:0] A_FLG = 3'd5;

  logic [15:0] tmr, cmpv;
  logic [7:0]  hi_wbuf, hi_rbuf;
  logic [1:0]  psel;
  logic [3:0]  mode;
  logic [2:0]  pre, pre_max;

  wire wr_tlo = wr_en && addr == A_TLO;
  wire wr_thi = wr_en && addr == A_THI;
  wire wr_flg = wr_en && addr == A_FLG;
  wire step   = cnt_en && src_tick;

  always_comb
    case (psel)
      2'd0:    pre_max = 3'd0;
      2'd1:    pre_max = 3'd1;
      2'd2:    pre_max = 3'd3;
      default: pre_max = 3'd7;
    endcase

  wire roll = step && !wr_tlo && pre >= pre_max;
  wire hit  = mode == TRIG_MODE && tmr == cmpv;
  wire fire = roll && hit;
  wire wrap = roll && !hit && tmr == 16'hFFFF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr      <= '0;
      pre      <= '0;
      cmpv     <= '0;
      hi_wbuf  <= '0;
      hi_rbuf  <= '0;
      psel     <= '0;
      mode     <= '0;
      trig     <= 1'b0;
      cmp_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (wr_tlo)     pre <= '0;
      else if (step)  pre <= roll ? 3'd0 : pre + 3'd1;

      if (wr_tlo)     tmr <= {hi_wbuf, wdata};
      else if (fire)  tmr <= '0;
      else if (roll)  tmr <= tmr + 16'd1;

      if (wr_thi) hi_wbuf <= wdata;
      if (rd_en && addr == A_TLO) hi_rbuf <= tmr[15:8];
      if (wr_en && addr == A_CLO) cmpv[7:0]  <= wdata;
      if (wr_en && addr == A_CHI) cmpv[15:8] <= wdata;
      if (wr_en && addr == A_CTL) begin
        psel <= wdata[1:0];
        mode <= wdata[5:2];
      end

      trig     <= fire;
      cmp_flag <= fire | (cmp_flag & ~(wr_flg & wdata[1]));
      ovf_flag <= wrap | (ovf_flag & ~(wr_flg & wdata[0]));
    end
  end

  always_comb
    case (addr)
      A_TLO:   rdata = tmr[7:0];
      A_THI:   rdata = hi_rbuf;
      A_CLO:   rdata = cmpv[7:0];
      A_CHI:   rdata = cmpv[15:8];
      A_CTL:   rdata = {2'b00, mode, psel};
      A_FLG:   rdata = {6'd0, cmp_flag, ovf_flag};
      default: rdata = 8'h00;
    endcase

  AST_TRIG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> tmr == 16'h0000); // R4
  AST_TRIG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> cmp_flag); // R5
  AST_OTHER_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    mode != TRIG_MODE |=> !trig); // R3
  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !wr_tlo) |=> ($stable(tmr) && $stable(pre))); // R11
  AST_HI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_thi && !step) |=> ($stable(tmr) && $stable(pre))); // R7
  AST_OVF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> tmr == 16'h0000); // R6
endmodule

// File: tb/test_cmp_timer.sv
module test_cmp_timer;
  logic clk = 0, rst_n = 0;
  logic cnt_en = 0, src_tick = 0;
  logic wr_en = 0, rd_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic trig, cmp_flag, ovf_flag;
  logic en_run = 0, tick_on = 1, alt = 0, phase = 0;
  int cyc = 0, trig_cnt = 0, total = 0, fails = 0;

  cmp_timer i_cmp_timer (.clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .src_tick(src_tick),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .trig(trig), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    phase    <= ~phase;
    cnt_en   <= en_run;
    src_tick <= tick_on && (!alt || phase);
    if (trig) trig_cnt <= trig_cnt + 1;
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output int v);
    @(negedge clk); rd_en = 1; addr = a; #1 v = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic cfg(logic [1:0] ps, logic [3:0] md, logic [15:0] cv, logic [15:0] ld);
    wr(3'd4, {2'b00, md, ps});
    wr(3'd2, cv[7:0]); wr(3'd3, cv[15:8]);
    wr(3'd1, ld[15:8]); wr(3'd0, ld[7:0]);
  endtask

  task automatic run_cycles(int n);
    @(posedge clk); #1 en_run = 1;
    repeat (n) @(posedge clk);
    #1 en_run = 0;
  endtask

  task automatic wait_trig();
    int k = 0;
    while (!trig && k < 3000) begin @(negedge clk); k++; end
  endtask

  task automatic meas(output int per);
    int t0;
    @(negedge clk); wait_trig(); t0 = cyc;
    @(negedge clk); wait_trig(); per = cyc - t0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    int v, per, t0, n0;
    int xs[4] = '{0, 1, 3, 6};
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 6; a++) begin rd(a[2:0], v); check("R1", v, 0); end
    check("R1 trig", int'(trig), 0);

    // R7 buffered high write
    cfg(2'd0, 4'd0, 16'd0, 16'h1234);
    rd(3'd0, v); check("R7 lo", v, 8'h34);
    rd(3'd1, v); check("R7 hi", v, 8'h12);
    wr(3'd1, 8'h56);
    rd(3'd0, v); check("R7 lo unchanged", v, 8'h34);
    rd(3'd1, v); check("R7 hi unchanged", v, 8'h12);
    wr(3'd0, 8'h78);
    rd(3'd0, v); check("R7 lo load", v, 8'h78);
    rd(3'd1, v); check("R7 hi load", v, 8'h56);

    // R9 captured high byte
    cfg(2'd0, 4'd0, 16'd0, 16'h12FF);
    rd(3'd0, v); check("R9 lo", v, 8'hFF);
    run_cycles(3);
    rd(3'd1, v); check("R9 stale hi", v, 8'h12);
    rd(3'd0, v); check("R9 lo after", v, 8'h02);
    rd(3'd1, v); check("R9 new hi", v, 8'h13);

    // R2 R3 period sweep
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 4; i++) begin
        cfg(s[1:0], 4'b1011, 16'(xs[i]), 16'd0);
        @(posedge clk); #1 en_run = 1;
        meas(per);
        @(posedge clk); #1 en_run = 0;
        check($sformatf("R3 period ps=%0d x=%0d", s, xs[i]), per, (xs[i] + 1) * (1 << s));
      end
    alt = 1;
    cfg(2'd1, 4'b1011, 16'd2, 16'd0);
    @(posedge clk); #1 en_run = 1;
    meas(per);
    @(posedge clk); #1 en_run = 0;
    check("R2 alternate ticks", per, 12);
    alt = 0;

    // R3 hold at compare, then deferred clear; R4
    cfg(2'd2, 4'b1011, 16'd2, 16'd0);
    n0 = trig_cnt;
    run_cycles(11);
    rd(3'd0, v); check("R3 holds x", v, 2);
    check("R3 no early trig", trig_cnt, n0);
    run_cycles(1);
    rd(3'd0, v); check("R4 zero at trig", v, 0);
    check("R4 one trig", trig_cnt, n0 + 1);

    // R3 other mode passes compare
    cfg(2'd0, 4'b1010, 16'd2, 16'd0);
    n0 = trig_cnt;
    run_cycles(10);
    rd(3'd0, v); check("R3 other mode count", v, 10);
    check("R3 other mode no trig", trig_cnt, n0);

    // R6 overflow
    wr(3'd5, 8'h03);
    cfg(2'd0, 4'd0, 16'd0, 16'hFFFE);
    run_cycles(1);
    rd(3'd5, v); check("R6 no flag before wrap", v, 0);
    run_cycles(1);
    rd(3'd5, v); check("R6 wrap flag", v, 1);
    rd(3'd0, v); check("R6 wrapped", v, 0);
    wr(3'd5, 8'h01);
    rd(3'd5, v); check("R6 clear", v, 0);
    cfg(2'd0, 4'b1011, 16'hFFFF, 16'hFFFE);
    run_cycles(2);
    rd(3'd5, v); check("R6 compare clear no ovf", v, 2);

    // R5 sticky compare flag
    wr(3'd5, 8'h01);
    rd(3'd5, v); check("R5 stays set", v, 2);
    wr(3'd5, 8'h02);
    rd(3'd5, v); check("R5 cleared", v, 0);

    // R8 high write keeps cadence
    cfg(2'd3, 4'b1011, 16'd3, 16'd0);
    @(posedge clk); #1 en_run = 1;
    @(negedge clk); wait_trig(); t0 = cyc;
    wr(3'd1, 8'hAA);
    wait_trig(); per = cyc - t0;
    @(posedge clk); #1 en_run = 0;
    check("R8 period with high write", per, 32);

    // R10 divider restart
    cfg(2'd2, 4'd0, 16'd0, 16'd0);
    run_cycles(2);
    wr(3'd0, 8'h00);
    run_cycles(3);
    rd(3'd0, v); check("R10 before full P", v, 0);
    run_cycles(1);
    rd(3'd0, v); check("R10 after full P", v, 1);

    // R11 freeze with ticks present, writes accepted
    rd(3'd0, n0);
    repeat (10) @(posedge clk);
    rd(3'd0, v); check("R11 frozen", v, n0);
    wr(3'd2, 8'h5A);
    rd(3'd2, v); check("R11 write taken", v, 8'h5A);
    wr(3'd4, 8'h2D);
    rd(3'd4, v); check("R11 ctrl write", v, 8'h2D);

    summary();
    $finish;
  end
endmodule